// File: doc/BRIEF.md
# Streaming Matrix Row Dot-Product Unit

This block speeds up dense matrix multiplication of 32-bit signed integers. A group of rows of the left matrix is first written into local storage, one bank per row, so that every row can be read in the same cycle. Columns of the right matrix are then streamed in one word per transfer. Each word is broadcast to all row lanes at once, and each lane multiplies it by the matching stored element and adds the product to its own accumulator. When the last element of a column has been taken in, the unit emits one result word per stored row, in row order. The stored rows stay in place, so any number of columns can follow one row load.

A single 32-bit input stream carries both kinds of traffic, with a mode bit that selects whether a word is a row element or a column element. The vector length N is set at run time on a side input and is captured at the start of each row load. Results leave on a 32-bit output stream with valid/ready and a flag on the final row. While results are still leaving, the input stream is held off.

Top module: `mrow_dot_engine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Row words (in_mode = 0) are stored row-major: accepted row word number w since the load pointer was last at its origin goes to row w / N, element w % N. After NUM_ROWS x N row words the pointer returns to row 0, element 0.
- R3: cfg_dim is captured only when a row word is accepted with the load pointer at row 0, element 0. A value of 0, or a value above MAX_N, is taken as MAX_N.
- R4: Column word k (in_mode = 1), counted from the start of a column, is multiplied by element k of every stored row. Each lane's sum restarts from zero at word 0 of a column.
- R5: Once the Nth column word has been accepted, in_ready stays 0 until the last result of that column has been taken, and is 1 again in the cycle after that.
- R6: Each complete column produces exactly NUM_ROWS results, row 0 first. out_last is 1 only on the result for row NUM_ROWS-1.
- R7: Elements and products are signed two's-complement. Sums are kept wider than 64 bits, and each output is the low 32 bits of the full sum, so overflow wraps.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R9: An accepted row word discards a partly received column (the next column word counts as word 0). An accepted column word returns the load pointer to row 0, element 0.
- R10: Stored rows stay in place across columns: several columns in a row use the same rows without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dim | input | $clog2(MAX_N+1) | Vector length N, captured at the start of a row load |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Unit can take an input word |
| in_mode | input | 1 | 0 = row element, 1 = column element |
| in_data | input | 32 | Input word, signed |
| out_valid | output | 1 | Result word is present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 32 | Result word, low 32 bits of the dot product |
| out_last | output | 1 | Marks the result for the final row |

## Verification
The column patterns include an all-zero column, which shows that the accumulators really clear. An all-ones column checks the row sums. Mixed-sign small values check sign handling, and columns at the extreme positive and negative values force 32-bit wrap, which separates a correct truncation from a saturating or narrow accumulator. The same rows serve every column in the table, so a loss of stored data shows up as a mismatch. Directed runs with N set to 1, to zero and to an out-of-range value test the length rule. A partial column followed by a reload, placed after a partial row load, shows whether stale sums or a stale load pointer leak into later results. A stalled consumer shows whether the output stays stable.

// File: rtl/mrow_pkg.sv
package mrow_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic {
    MODE_ROW = 1'b0,
    MODE_COL = 1'b1
  } in_mode_e;
endpackage

// File: rtl/mrow_ctrl.sv
module mrow_ctrl
  import mrow_pkg::*;
#(
  parameter int NUM_ROWS = 32,
  parameter int MAX_N    = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIM_W-1:0]     cfg_dim,
  input  logic                 in_valid,
  input  logic                 in_mode,
  input  word_t                in_data,
  output logic                 in_ready,
  input  logic                 drain_fin,
  output logic                 wr_en,
  output logic [R_W-1:0]       wr_row,
  output logic [K_W-1:0]       wr_addr,
  output word_t                wr_data,
  output logic                 rd_en,
  output logic [K_W-1:0]       rd_addr,
  output logic                 s1_v,
  output logic                 s1_first,
  output word_t                s1_b,
  output logic                 col_done
);
  localparam int DIM_W = $clog2(MAX_N + 1);
  localparam int K_W   = (MAX_N > 1) ? $clog2(MAX_N) : 1;
  localparam int R_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  logic [R_W-1:0]   ld_row_q;
  logic [K_W-1:0]   ld_elem_q;
  logic [K_W-1:0]   col_idx_q;
  logic [DIM_W-1:0] dim_q;
  logic             busy_q;
  logic             s1_last_q;

  logic             take, row_take, col_take, at_origin, row_end, col_end;
  logic [DIM_W-1:0] eff_cfg, n_now;

  assign in_ready  = !busy_q;
  assign take      = in_valid && !busy_q;
  assign row_take  = take && (in_mode == MODE_ROW);
  assign col_take  = take && (in_mode == MODE_COL);
  assign at_origin = (ld_row_q == '0) && (ld_elem_q == '0);

  always_comb begin
    if (cfg_dim == '0 || cfg_dim > DIM_W'(MAX_N)) eff_cfg = DIM_W'(MAX_N);
    else                                          eff_cfg = cfg_dim;
  end

  assign n_now   = at_origin ? eff_cfg : dim_q;
  assign row_end = (DIM_W'(ld_elem_q) == n_now - DIM_W'(1));
  assign col_end = (DIM_W'(col_idx_q) == dim_q - DIM_W'(1));

  assign wr_en   = row_take;
  assign wr_row  = ld_row_q;
  assign wr_addr = ld_elem_q;
  assign wr_data = in_data;
  assign rd_en   = col_take;
  assign rd_addr = col_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_row_q  <= '0;
      ld_elem_q <= '0;
      col_idx_q <= '0;
      dim_q     <= DIM_W'(MAX_N);
      busy_q    <= 1'b0;
      s1_v      <= 1'b0;
      s1_first  <= 1'b0;
      s1_last_q <= 1'b0;
      s1_b      <= '0;
      col_done  <= 1'b0;
    end else begin
      s1_v     <= col_take;
      col_done <= s1_v && s1_last_q;
      if (col_take) begin
        s1_first  <= (col_idx_q == '0);
        s1_last_q <= col_end;
        s1_b      <= in_data;
      end

      if (row_take) begin
        if (at_origin) dim_q <= eff_cfg;
        col_idx_q <= '0;
        if (row_end) begin
          ld_elem_q <= '0;
          ld_row_q  <= (ld_row_q == R_W'(NUM_ROWS - 1)) ? '0 : ld_row_q + R_W'(1);
        end else begin
          ld_elem_q <= ld_elem_q + K_W'(1);
        end
      end

      if (col_take) begin
        ld_row_q  <= '0;
        ld_elem_q <= '0;
        col_idx_q <= col_end ? '0 : col_idx_q + K_W'(1);
        if (col_end) busy_q <= 1'b1;
      end

      if (drain_fin) busy_q <= 1'b0;
    end
  end

  // R3: the captured length never leaves 1..MAX_N
  a_r3_dim_in_range: assert property (@(posedge clk) disable iff (rst)
    (dim_q >= DIM_W'(1)) && (dim_q <= DIM_W'(MAX_N)));

  // R4: the column position never reaches the captured length
  a_r4_col_bound: assert property (@(posedge clk) disable iff (rst)
    DIM_W'(col_idx_q) < dim_q);

  // R5: input is blocked only after an accepted column word
  a_r5_busy_source: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(in_valid && in_mode == MODE_COL));
endmodule

// File: rtl/mrow_lane.sv
module mrow_lane
  import mrow_pkg::*;
#(
  parameter int MAX_N = 16,
  parameter int ACC_W = 68
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [K_W-1:0] wr_addr,
  input  word_t          wr_data,
  input  logic           rd_en,
  input  logic [K_W-1:0] rd_addr,
  input  logic           s1_v,
  input  logic           s1_first,
  input  word_t          s1_b,
  output word_t          res
);
  localparam int K_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  word_t                    bank [MAX_N];
  word_t                    a_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [63:0]       prod;
  logic signed [ACC_W-1:0]  prod_ext;

  always_ff @(posedge clk) begin
    if (wr_en) bank[wr_addr] <= wr_data;
    if (rd_en) a_q <= bank[rd_addr];
  end

  assign prod     = $signed(a_q) * $signed(s1_b);
  assign prod_ext = ACC_W'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (s1_v) begin
      acc_q <= s1_first ? prod_ext : acc_q + prod_ext;
    end
  end

  assign res = acc_q[WORD_W-1:0];

  // R4: a lane sum changes only when a column element is in flight
  a_r4_acc_quiet: assert property (@(posedge clk) disable iff (rst)
    !s1_v |=> $stable(acc_q));
endmodule

// File: rtl/mrow_drain.sv
module mrow_drain
  import mrow_pkg::*;
#(
  parameter int NUM_ROWS = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NUM_ROWS-1:0][WORD_W-1:0] res_all,
  input  logic                         out_ready,
  output logic                         out_valid,
  output word_t                        out_data,
  output logic                         out_last,
  output logic                         fin
);
  localparam int R_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;

  logic [R_W-1:0] idx_q;
  logic           hs;
  logic [R_W-1:0] nxt;

  assign hs  = out_valid && out_ready;
  assign fin = hs && out_last;
  assign nxt = idx_q + R_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      idx_q     <= '0;
    end else if (start) begin
      out_valid <= 1'b1;
      idx_q     <= '0;
      out_data  <= res_all[0];
      out_last  <= (NUM_ROWS == 1);
    end else if (hs) begin
      if (out_last) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end else begin
        idx_q    <= nxt;
        out_data <= res_all[nxt];
        out_last <= (nxt == R_W'(NUM_ROWS - 1));
      end
    end
  end

  // R8: a stalled result holds
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R6: the final row ends the result burst
  a_r6_last_ends: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last |=> !out_valid);
endmodule

// File: rtl/mrow_dot_engine.sv
module mrow_dot_engine
  import mrow_pkg::*;
#(
  parameter int NUM_ROWS = 32,
  parameter int MAX_N    = 16,
  localparam int DIM_W   = $clog2(MAX_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIM_W-1:0] cfg_dim,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_mode,
  input  logic [31:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_last
);
  localparam int K_W   = (MAX_N > 1) ? $clog2(MAX_N) : 1;
  localparam int R_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int ACC_W = 2 * WORD_W + K_W;

  logic           wr_en, rd_en, s1_v, s1_first, col_done, drain_fin;
  logic [R_W-1:0] wr_row;
  logic [K_W-1:0] wr_addr, rd_addr;
  word_t          wr_data, s1_b;
  logic [NUM_ROWS-1:0][WORD_W-1:0] res_all;

  mrow_ctrl #(.NUM_ROWS(NUM_ROWS), .MAX_N(MAX_N)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_dim  (cfg_dim),
    .in_valid (in_valid),
    .in_mode  (in_mode),
    .in_data  (in_data),
    .in_ready (in_ready),
    .drain_fin(drain_fin),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .s1_v     (s1_v),
    .s1_first (s1_first),
    .s1_b     (s1_b),
    .col_done (col_done)
  );

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_lane
    logic lane_wr;
    assign lane_wr = wr_en && (wr_row == R_W'(r));
    mrow_lane #(.MAX_N(MAX_N), .ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (lane_wr),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .s1_v    (s1_v),
      .s1_first(s1_first),
      .s1_b    (s1_b),
      .res     (res_all[r])
    );
  end

  mrow_drain #(.NUM_ROWS(NUM_ROWS)) u_drain (
    .clk      (clk),
    .rst      (rst),
    .start    (col_done),
    .res_all  (res_all),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .fin      (drain_fin)
  );

  // R5: input and output never overlap
  a_r5_no_input_during_drain: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
endmodule

// File: tb/mrow_dot_engine_test.sv
module mrow_dot_engine_test;
  localparam int ROWS  = 4;
  localparam int MAXN  = 8;
  localparam int DW    = $clog2(MAXN + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] cfg_dim = DW'(4);
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_mode = 1'b0;
  logic [31:0]   in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_data;
  logic          out_last;

  int nvec = 0;
  int nbad = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] A [ROWS][MAXN];

  always #10 clk = ~clk;

  mrow_dot_engine #(.NUM_ROWS(ROWS), .MAX_N(MAXN)) uut (
    .clk(clk), .rst(rst), .cfg_dim(cfg_dim),
    .in_valid(in_valid), .in_ready(in_ready), .in_mode(in_mode), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  // column patterns for N = 4, rows loaded once (R10)
  localparam logic [31:0] COLS [6][4] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFE, 32'h0000_0003},
    '{32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000},
    '{32'h0000_0005, 32'hFFFF_FFF9, 32'h0001_0000, 32'hFFFF_0000},
    '{32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF}
  };

  function automatic logic [31:0] gen(int seed, int r, int k);
    int v;
    v = seed * 32'h0000_9E37 + r * 32'h0100_0193 - k * 32'h3B9A_CA07 + (r ^ k) * 977;
    return 32'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send_word(input bit mode, input logic [31:0] d);
    in_valid = 1'b1;
    in_mode  = mode;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load_rows(input int cfg, input int eff, input int seed);
    cfg_dim = DW'(cfg);
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < eff; k++) begin
        A[r][k] = gen(seed, r, k);
        send_word(1'b0, A[r][k]);
      end
    end
  endtask

  task automatic run_column(input int n, input logic [31:0] b [MAXN],
                            input bit stall, input string req);
    longint s;
    logic [31:0] expv, hold;
    for (int k = 0; k < n; k++) send_word(1'b1, b[k]);
    chk(in_ready === 1'b0, "R5", "in_ready after last column word", 32'(in_ready), 32'd0);
    for (int r = 0; r < ROWS; r++) begin
      s = 0;
      for (int k = 0; k < n; k++)
        s += longint'($signed(A[r][k])) * longint'($signed(b[k]));
      expv = s[31:0];
      if (stall && r == 0) begin
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        hold = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b1 && out_data === hold, "R8", "stalled result held",
            out_data, hold);
        out_ready = 1'b1;
      end
      while (!out_valid) @(negedge clk);
      chk(out_data === expv, req, $sformatf("row %0d result", r), out_data, expv);
      chk(out_last === (r == ROWS - 1), "R6", $sformatf("row %0d last flag", r),
          32'(out_last), 32'(r == ROWS - 1));
      @(negedge clk);
    end
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R5", "input released after drain",
        32'(in_ready), 32'd1);
  endtask

  initial begin
    logic [31:0] bc [MAXN];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);

    // R2 R4 R7 R10: one row load, table of columns
    load_rows(4, 4, 1);
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < MAXN; k++) bc[k] = (k < 4) ? COLS[v][k] : 32'h0;
      run_column(4, bc, v == 2, "R4_R7_R10");
    end

    // R3: N = 1
    load_rows(1, 1, 3);
    bc[0] = 32'hFFFF_FFFD;
    run_column(1, bc, 1'b0, "R3_dim1");

    // R3: zero length taken as MAX_N
    load_rows(0, MAXN, 4);
    for (int k = 0; k < MAXN; k++) bc[k] = gen(17, 0, k);
    run_column(MAXN, bc, 1'b0, "R3_dim0");

    // R3: out-of-range length taken as MAX_N
    load_rows(12, MAXN, 5);
    for (int k = 0; k < MAXN; k++) bc[k] = gen(23, 1, k);
    run_column(MAXN, bc, 1'b1, "R3_dim_over");

    // R9: partial row load, then a column word resets the load pointer
    cfg_dim = DW'(3);
    for (int i = 0; i < 5; i++) send_word(1'b0, 32'hDEAD_0000 + 32'(i));
    send_word(1'b1, 32'h1234_5678);
    load_rows(3, 3, 9);
    // R9: partial column abandoned by a reload
    send_word(1'b1, 32'h7777_7777);
    send_word(1'b1, 32'h5555_5555);
    load_rows(3, 3, 11);
    bc[0] = 32'h0000_0009; bc[1] = 32'hFFFF_FFF0; bc[2] = 32'h0012_3456;
    run_column(3, bc, 1'b0, "R9");

    // R2 R10: second column on the same rows with wrapped pointer
    bc[0] = 32'h8000_0001; bc[1] = 32'h0000_0000; bc[2] = 32'h7FFF_FFFE;
    run_column(3, bc, 1'b0, "R2_R10");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        finished = 1;
        nvec++;
        nbad++;
        $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
      end
    end
  end
endmodule